// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block supervises a system microcontroller from inside a larger controller chip. It watches a watchdog line driven by the microcontroller, two enable lines, a thermal-shutdown flag and a regulator undervoltage flag. From these it drives an active-low reset to the microcontroller, an enable for the supply regulator, a global enable that gates downstream drivers, and a 3-bit code naming the condition currently in control.

All timing uses clock-cycle counters. A silent watchdog line does not cause a single reset. It causes a repeating train of short reset pulses, one per timeout period, until the software shows signs of life again. Once reset is released, the downstream drivers stay gated off until the first watchdog edge proves the software is running. Sleep, thermal shutdown and undervoltage hold reset low for as long as they last. Each is followed by a power-on delay before reset is released. The watchdog can be removed by a parameter; the driver enable then follows the end of the power-on delay.

Top module: `wdog_supervisor`

## Requirements
- R1: The block is enabled when either enable input is high. When both are low, the next cycle shows regulator enable 0, reset 0, driver enable 0 and code 1 (sleep).
- R2: The watchdog input passes through two synchronizing flops. A rising or a falling transition on it restarts the timeout count, so edges spaced closer than WD_TIMEOUT cycles keep reset high.
- R3: After WD_TIMEOUT cycles with no watchdog edge, reset goes low with code 4 for RST_PULSE cycles. The count then starts again, and the pulse repeats every period while no edge arrives. An edge ends a pulse in progress.
- R4: RST_PULSE defaults to ceil(WD_TIMEOUT*14/200). POR_DELAY defaults to WD_TIMEOUT.
- R5: While enabled with the thermal flag high, reset and regulator enable are 0 and the code is 2, for the whole fault, with no pulses.
- R6: While enabled, with the thermal flag low and the undervoltage flag high, reset is 0, regulator enable stays 1 and the code is 3.
- R7: After reset, sleep, thermal or undervoltage ends, reset stays 0 with code 5 for POR_DELAY cycles. Reset then goes high.
- R8: The driver enable is 1 only while reset is high. It rises on the first watchdog edge seen after reset release. Any fault, the power-on delay or a watchdog pulse clears it.
- R9: Fault priority is sleep (1) over thermal (2) over undervoltage (3) over watchdog (4). Code 5 marks the power-on delay and code 0 means no fault.
- R10: With WD_DISABLE set, no watchdog pulses occur, and the driver enable rises together with reset at the end of the power-on delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdi_i | input | 1 | Watchdog line from the microcontroller (asynchronous) |
| en_lo_i | input | 1 | Enable input, logic level |
| en_hi_i | input | 1 | Enable input, from the battery-level detector |
| tsd_i | input | 1 | Thermal-shutdown flag |
| uv_i | input | 1 | Regulator undervoltage flag |
| npor_o | output | 1 | Active-low microcontroller reset |
| reg_en_o | output | 1 | Regulator enable |
| drv_en_o | output | 1 | Global enable for downstream drivers |
| fault_code_o | output | 3 | Active condition: 0 none, 1 sleep, 2 thermal, 3 undervoltage, 4 watchdog, 5 power-on delay |

## Verification
The assertions assume that the enable, thermal and undervoltage inputs are already synchronous to the clock, because only the watchdog line is synchronized inside the block. The stimulus changes every input only on the falling clock edge. The assertions also assume the timing parameters are at least 1. The bench keeps fault inputs steady for many cycles between changes, so the power-on delay and pulse train can run to completion. It also varies the watchdog toggle rate around the timeout, so that both kept-alive and timed-out stretches occur.

// File: rtl/wdog_sup_pkg.sv
package wdog_sup_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_SLEEP = 3'd1,
    FLT_THERM = 3'd2,
    FLT_UV    = 3'd3,
    FLT_WDOG  = 3'd4,
    FLT_POR   = 3'd5
  } flt_code_e;
endpackage

// File: rtl/wdog_sup_sync.sv
// Two-flop synchronizer on the watchdog line plus a third stage for edge detect.
module wdog_sup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);
  localparam int unsigned DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], async_i};
  end

  // Either polarity counts as activity.
  assign edge_o = chain_q[DEPTH-1] ^ chain_q[DEPTH-2];
endmodule

// File: rtl/wdog_sup_por.sv
// Power-on delay: restarts while hold_i is high, finishes after DELAY clear cycles.
module wdog_sup_por #(
  parameter int unsigned DELAY = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic done_q_o,
  output logic done_n_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    if (hold_i) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(DELAY - 1)) begin
        cnt_n  = '0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done_q_o = done_q;
  assign done_n_o = done_n;
endmodule

// File: rtl/wdog_sup_timer.sv
// Watchdog timeout counter and reset pulse generator.
module wdog_sup_timer #(
  parameter int unsigned TIMEOUT = 200,
  parameter int unsigned PULSE   = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic edge_i,
  output logic pulse_n_o
);
  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam int unsigned PW = $clog2(PULSE + 1);

  logic [TW-1:0] wait_q, wait_n;
  logic [PW-1:0] width_q, width_n;
  logic          pulse_q, pulse_n;

  always_comb begin
    wait_n  = wait_q;
    width_n = width_q;
    pulse_n = pulse_q;
    if (!active_i || edge_i) begin
      wait_n  = '0;
      width_n = '0;
      pulse_n = 1'b0;
    end else if (pulse_q) begin
      if (width_q == PW'(PULSE - 1)) begin
        width_n = '0;
        pulse_n = 1'b0;
      end else begin
        width_n = width_q + 1'b1;
      end
    end else if (wait_q == TW'(TIMEOUT - 1)) begin
      wait_n  = '0;
      width_n = '0;
      pulse_n = 1'b1;
    end else begin
      wait_n = wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q  <= '0;
      width_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      wait_q  <= wait_n;
      width_q <= width_n;
      pulse_q <= pulse_n;
    end
  end

  assign pulse_n_o = pulse_n;
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned WD_TIMEOUT = 200,
  parameter int unsigned RST_PULSE  = (WD_TIMEOUT * 14 + 199) / 200,
  parameter int unsigned POR_DELAY  = WD_TIMEOUT,
  parameter bit          WD_DISABLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdi_i,
  input  logic       en_lo_i,
  input  logic       en_hi_i,
  input  logic       tsd_i,
  input  logic       uv_i,
  output logic       npor_o,
  output logic       reg_en_o,
  output logic       drv_en_o,
  output logic [2:0] fault_code_o
);
  import wdog_sup_pkg::*;

  logic wd_edge, en_any, hold, por_done_q, por_done_n, pulse_n, wd_active, arm_n;
  flt_code_e code_n;

  assign en_any    = en_lo_i | en_hi_i;
  assign hold      = ~en_any | tsd_i | uv_i;
  assign wd_active = por_done_q & ~hold & ~WD_DISABLE;

  wdog_sup_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(wdi_i), .edge_o(wd_edge)
  );

  wdog_sup_por #(.DELAY(POR_DELAY)) u_por (
    .clk(clk), .rst(rst), .hold_i(hold),
    .done_q_o(por_done_q), .done_n_o(por_done_n)
  );

  wdog_sup_timer #(.TIMEOUT(WD_TIMEOUT), .PULSE(RST_PULSE)) u_timer (
    .clk(clk), .rst(rst), .active_i(wd_active), .edge_i(wd_edge),
    .pulse_n_o(pulse_n)
  );

  // Driver gating: either waits for the first watchdog edge or follows the delay.
  generate
    if (WD_DISABLE) begin : g_no_wd
      assign arm_n = ~hold & por_done_n;
    end else begin : g_wd
      logic arm_q;
      always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= arm_n;
      end
      assign arm_n = (hold | ~por_done_n | pulse_n) ? 1'b0
                   : (arm_q | (wd_edge & por_done_q));
    end
  endgenerate

  // Priority: sleep, thermal, undervoltage, then delay/watchdog.
  always_comb begin
    if (!en_any)          code_n = FLT_SLEEP;
    else if (tsd_i)       code_n = FLT_THERM;
    else if (uv_i)        code_n = FLT_UV;
    else if (!por_done_n) code_n = FLT_POR;
    else if (pulse_n)     code_n = FLT_WDOG;
    else                  code_n = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      npor_o       <= 1'b0;
      reg_en_o     <= 1'b0;
      drv_en_o     <= 1'b0;
      fault_code_o <= FLT_POR;
    end else begin
      npor_o       <= ~hold & por_done_n & ~pulse_n;
      reg_en_o     <= en_any & ~tsd_i;
      drv_en_o     <= arm_n;
      fault_code_o <= code_n;
    end
  end
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int unsigned RST_PULSE = 14
) (
  input logic       clk,
  input logic       rst,
  input logic       en_lo_i,
  input logic       en_hi_i,
  input logic       tsd_i,
  input logic       uv_i,
  input logic       npor_o,
  input logic       reg_en_o,
  input logic       drv_en_o,
  input logic [2:0] fault_code_o
);
  localparam int unsigned RW = $clog2(RST_PULSE + 2);
  logic [RW-1:0] wd_run;

  always_ff @(posedge clk) begin
    if (rst || fault_code_o != 3'd4) wd_run <= '0;
    else if (wd_run != {RW{1'b1}})   wd_run <= wd_run + 1'b1;
  end

  a_r1_sleep: assert property (@(posedge clk) disable iff (rst)
    !(en_lo_i || en_hi_i) |=> (!npor_o && !reg_en_o && !drv_en_o));

  a_r5_thermal: assert property (@(posedge clk) disable iff (rst)
    ((en_lo_i || en_hi_i) && tsd_i) |=> (!npor_o && !reg_en_o && fault_code_o == 3'd2));

  a_r6_undervolt: assert property (@(posedge clk) disable iff (rst)
    ((en_lo_i || en_hi_i) && !tsd_i && uv_i) |=> (!npor_o && reg_en_o && fault_code_o == 3'd3));

  a_r8_drv_needs_release: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> npor_o);

  a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
    wd_run <= RW'(RST_PULSE));

  a_r9_code_legal: assert property (@(posedge clk) disable iff (rst)
    fault_code_o <= 3'd5);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst(rst), .en_lo_i(en_lo_i), .en_hi_i(en_hi_i),
  .tsd_i(tsd_i), .uv_i(uv_i), .npor_o(npor_o), .reg_en_o(reg_en_o),
  .drv_en_o(drv_en_o), .fault_code_o(fault_code_o)
);

// File: tb/wdog_supervisor_bench.sv
`timescale 1ns/1ps
module wdog_supervisor_bench;
  localparam int TO_B    = 40;
  localparam int PULSE_B = (TO_B * 14 + 199) / 200;  // R4 default: 3
  localparam int POR_B   = TO_B;                     // R4 default

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdi = 1'b0, en_lo = 1'b0, en_hi = 1'b0, tsd = 1'b0, uv = 1'b0;
  logic npor, reg_en, drv_en, npor2, reg_en2, drv_en2;
  logic [2:0] code, code2;
  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned seed_val;

  always #5 clk = ~clk;

  wdog_supervisor #(.WD_TIMEOUT(TO_B)) u_wdog_supervisor (
    .clk(clk), .rst(rst), .wdi_i(wdi), .en_lo_i(en_lo), .en_hi_i(en_hi),
    .tsd_i(tsd), .uv_i(uv), .npor_o(npor), .reg_en_o(reg_en),
    .drv_en_o(drv_en), .fault_code_o(code));

  wdog_supervisor #(.WD_TIMEOUT(TO_B), .WD_DISABLE(1'b1)) u_wdog_supervisor_nowd (
    .clk(clk), .rst(rst), .wdi_i(wdi), .en_lo_i(en_lo), .en_hi_i(en_hi),
    .tsd_i(tsd), .uv_i(uv), .npor_o(npor2), .reg_en_o(reg_en2),
    .drv_en_o(drv_en2), .fault_code_o(code2));

  // Reference model built from the requirements.
  bit m_s1, m_s2, m_s3, m_edge, m_pd, m_pu, m_arm, m_flt, m_en, pd_old, act;
  int m_pc, m_wc, m_pk;
  bit e_npor, e_reg, e_drv;
  int e_code;

  function automatic int code_of(bit en, bit t, bit u, bit pd, bit pu);
    if (!en) return 1;
    if (t) return 2;
    if (u) return 3;
    if (!pd) return 5;
    if (pu) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pd = 0; m_pu = 0; m_arm = 0;
      m_pc = 0; m_wc = 0; m_pk = 0;
      e_npor = 0; e_reg = 0; e_drv = 0; e_code = 5;
    end else begin
      m_en = en_lo | en_hi;
      m_flt = !m_en || tsd || uv;
      m_edge = m_s2 ^ m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wdi;
      pd_old = m_pd;
      if (m_flt) begin m_pc = 0; m_pd = 0; end
      else if (!m_pd) begin
        if (m_pc == POR_B - 1) begin m_pc = 0; m_pd = 1; end else m_pc++;
      end
      act = pd_old && !m_flt;
      if (!act || m_edge) begin m_wc = 0; m_pu = 0; m_pk = 0; end
      else if (m_pu) begin
        if (m_pk == PULSE_B - 1) begin m_pu = 0; m_pk = 0; end else m_pk++;
      end else if (m_wc == TO_B - 1) begin m_pu = 1; m_wc = 0; end
      else m_wc++;
      if (m_flt || !m_pd || m_pu) m_arm = 0;
      else if (m_edge && pd_old) m_arm = 1;
      e_npor = !m_flt && m_pd && !m_pu;
      e_reg  = m_en && !tsd;
      e_drv  = m_arm;
      e_code = code_of(m_en, tsd, uv, m_pd, m_pu);
    end
  end

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  function automatic string req_of(int c);
    case (c)
      1: return "R1";
      2: return "R5";
      3: return "R6";
      4: return "R3";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // One clock; compare the model at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk(npor == e_npor, {req_of(e_code), " npor"}, npor, e_npor);
    chk(reg_en == e_reg, {req_of(e_code), " reg_en"}, reg_en, e_reg);
    chk(drv_en == e_drv, "R8 drv_en", drv_en, e_drv);
    chk(int'(code) == e_code, "R9 code", code, e_code);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int low_len;
    int waited;
    seed_val = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // Reset state (R7 code)
    chk(npor == 0 && drv_en == 0 && reg_en == 0, "R7 reset npor", npor, 0);
    chk(code == 3'd5, "R7 reset code", code, 5);
    rst = 1'b0;
    ticks(3);
    chk(code == 3'd1 && reg_en == 0, "R1 sleep", code, 1);
    en_hi = 1'b1;
    ticks(POR_B - 2);
    chk(npor == 0 && code == 3'd5, "R7 delay running", code, 5);
    ticks(4);
    chk(npor == 1, "R7 released", npor, 1);
    chk(drv_en == 0, "R8 waits for edge", drv_en, 0);
    wdi = ~wdi;
    ticks(4);
    chk(drv_en == 1, "R8 armed", drv_en, 1);
    // R2: alternating polarity edges keep reset high
    for (int k = 0; k < 5; k++) begin
      ticks(30);
      wdi = ~wdi;
    end
    ticks(30);
    chk(npor == 1 && code == 3'd0, "R2 kept alive", code, 0);
    // R3 and R4: stop toggling, measure pulses
    waited = 0;
    while (npor == 1 && waited < 200) begin tick(); waited++; end
    chk(code == 3'd4, "R3 alarm code", code, 4);
    low_len = 0;
    while (npor == 0 && low_len < 50) begin tick(); low_len++; end
    chk(low_len == PULSE_B, "R4 pulse width", low_len, PULSE_B);
    waited = 0;
    while (npor == 1 && waited < 200) begin tick(); waited++; end
    chk(waited == TO_B, "R3 repeat period", waited, TO_B);
    chk(npor2 == 1 && drv_en2 == 1 && code2 == 3'd0, "R10 no alarm", npor2, 1);
    wdi = ~wdi;
    ticks(10);
    // Thermal
    tsd = 1'b1;
    ticks(2);
    chk(reg_en == 0 && code == 3'd2, "R5 thermal", code, 2);
    uv = 1'b1;
    ticks(100);
    chk(npor == 0 && code == 3'd2, "R9 thermal over uv", code, 2);
    tsd = 1'b0;
    ticks(2);
    chk(reg_en == 1 && code == 3'd3 && npor == 0, "R6 undervoltage", code, 3);
    uv = 1'b0;
    ticks(2);
    chk(code == 3'd5, "R7 after fault", code, 5);
    en_hi = 1'b0; tsd = 1'b1;
    ticks(2);
    chk(code == 3'd1 && reg_en == 0, "R9 sleep over thermal", code, 1);
    tsd = 1'b0; en_lo = 1'b1;
    ticks(POR_B + 3);
    chk(npor == 1 && reg_en == 1, "R1 single enable", npor, 1);
    chk(drv_en2 == 1 && npor2 == 1, "R10 drv after delay", drv_en2, 1);
    // Random phases: dense then sparse toggling
    for (int ph = 0; ph < 2; ph++) begin
      for (int c = 0; c < 3000; c++) begin
        int r;
        r = int'($urandom % 1000);
        if (r < (ph == 0 ? 80 : 20)) wdi = ~wdi;
        if (r == 999) tsd = ~tsd;
        if (r == 998) uv = ~uv;
        if (r == 997) en_lo = ~en_lo;
        if (r == 996) en_hi = ~en_hi;
        tick();
      end
      tsd = 1'b0; uv = 1'b0; en_lo = 1'b1;
      ticks(60);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule